// File: doc/BRIEF.md
# Fractional-N Divider Modulator

This block computes the feedback divide ratio of a fractional-N frequency synthesizer and issues a new ratio on every reference-clock cycle. Software or a sequencer programs a channel word. The word has an integer part and a 23-bit fractional part. A signed frequency-modulation offset, already shaped by an upstream digital filter, is added to that fraction on every cycle. The resulting effective fraction drives a third-order multi-stage noise-shaping (MASH 1-1-1) accumulator network. The network produces a small integer correction that dithers the divide ratio around the integer part. Over many cycles the mean ratio equals the programmed fractional value plus the modulation.

The block runs directly on the reference clock, so each rising edge is one reference cycle. The divide ratio output is registered. A channel write restarts the noise shaper from a clean state. Dropping the enable parks the divider on the plain integer value.

Top module: `fracn_div_mod`

## Requirements
- R1: A synchronous active-high reset clears the stored integer and fraction to zero and drives `div_out` to 0 on the next edge.
- R2: On a clock edge with `chan_wr` high, the block stores `chan_int` and `chan_frac` and clears all three accumulators and every carry delay register. `div_out` shows the new integer value after that edge. A write takes priority over `en`.
- R3: On an edge with `en` low and no write, `div_out` becomes the stored integer and the accumulators and carry delays are cleared. The modulation offset has no effect on the output.
- R4: The effective fraction is the stored fraction plus `mod_off`, where `mod_off` is read as MOD_W-bit two's complement. The sum is clamped to the range 0 to 2^23-1.
- R5: Three 23-bit accumulators form a cascade. Stage 1 adds the effective fraction. Stage k (k > 1) adds the new 23-bit sum of stage k-1. Each stage keeps its sum modulo 2^23 and gives a carry bit c_k. The accumulators advance only on enabled edges without a write.
- R6: On an enabled edge without a write, `div_out` becomes int + y. Here y = c1 + (c2[n] - c2[n-1]) + (c3[n] - 2*c3[n-1] + c3[n-2]), with delayed carries counting as 0 after a clear. y always lies in -3..+4.
- R7: With a constant fraction and zero offset, the mean of `div_out` over several thousand enabled cycles equals int + frac/2^23. The accumulated sum stays within 8 of the ideal value.
- R8: With zero fraction and zero offset, every enabled output equals the integer exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one divide value per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Fractional and modulation operation enable |
| chan_wr | input | 1 | Channel word write strobe |
| chan_int | input | INT_W | Integer part of the channel word (3 or more when enabled) |
| chan_frac | input | FRAC_W | Fractional part of the channel word |
| mod_off | input | MOD_W | Signed filtered modulation offset, added each cycle |
| div_out | output | INT_W+1 | Registered instantaneous divide ratio |

## Verification
The hardest corners to reach are the saturation limits of the effective fraction. Random fractions and offsets almost never drive the sum past zero or past the top of the 23-bit range while the accumulators are already mid-sequence. Directed runs therefore pair a fraction near 0 with a large negative offset, and a fraction at full scale with a positive offset. Every output is compared with a cycle-exact model built from the requirement equations. Random traffic adds writes and enable drops that land at arbitrary accumulator states, which tests the synchronous clear of the carry delays.

// File: rtl/fnmod_pkg.sv
package fnmod_pkg;
  localparam int MASH_ORDER = 3;
  localparam int CORR_W     = 4;
  typedef logic signed [CORR_W-1:0] corr_t;
endpackage

// File: rtl/fnmod_offset_sat.sv
module fnmod_offset_sat #(
  parameter int FRAC_W = 23,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [MOD_W-1:0]  mod_i,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int SUM_W = FRAC_W + 2;
  localparam int EXT_W = SUM_W - MOD_W;

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] top_lim;

  always_comb begin
    top_lim = $signed({2'b00, {FRAC_W{1'b1}}});
    sum = $signed({2'b00, frac_i}) + $signed({{EXT_W{mod_i[MOD_W-1]}}, mod_i});
    if (sum < 0)
      frac_o = '0;
    else if (sum > top_lim)
      frac_o = '1;
    else
      frac_o = sum[FRAC_W-1:0];
  end

  // R4
  pos_offset_chk: assert property (@(posedge clk) disable iff (rst)
    !mod_i[MOD_W-1] |-> frac_o >= frac_i);
  // R4
  neg_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_i[MOD_W-1] || mod_i == '0) |-> frac_o <= frac_i);
endmodule

// File: rtl/fnmod_mash_stage.sv
module fnmod_mash_stage #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] acc;
  logic [W:0]   wide;

  always_comb begin
    wide    = {1'b0, acc} + {1'b0, in_i};
    sum_o   = wide[W-1:0];
    carry_o = wide[W];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      acc <= '0;
    else if (adv)
      acc <= sum_o;
  end

  // R2
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc == '0);
  // R5
  carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> sum_o < in_i);
endmodule

// File: rtl/fnmod_noise_cancel.sv
module fnmod_noise_cancel
  import fnmod_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  adv,
  input  logic  c1,
  input  logic  c2,
  input  logic  c3,
  output corr_t corr_o
);
  logic c2_d, c3_d, c3_dd;

  always_comb begin
    corr_o = corr_t'({1'b0, c1}) + corr_t'({1'b0, c2}) - corr_t'({1'b0, c2_d})
           + corr_t'({1'b0, c3}) - corr_t'({1'b0, c3_d, 1'b0}) + corr_t'({1'b0, c3_dd});
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (adv) begin
      c2_d  <= c2;
      c3_d  <= c3;
      c3_dd <= c3_d;
    end
  end

  // R6
  corr_range_chk: assert property (@(posedge clk) disable iff (rst)
    adv |-> (corr_o >= -4'sd3 && corr_o <= 4'sd4));
endmodule

// File: rtl/fracn_div_mod.sv
module fracn_div_mod
  import fnmod_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              chan_wr,
  input  logic [INT_W-1:0]  chan_int,
  input  logic [FRAC_W-1:0] chan_frac,
  input  logic [MOD_W-1:0]  mod_off,
  output logic [INT_W:0]    div_out
);
  localparam int OUT_W = INT_W + 1;

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] frac_eff;
  logic              clr, adv;
  logic [FRAC_W-1:0] stage_in  [MASH_ORDER];
  logic [FRAC_W-1:0] stage_sum [MASH_ORDER];
  logic [MASH_ORDER-1:0] carry;
  corr_t             corr;
  logic signed [OUT_W-1:0] div_next;

  assign clr = chan_wr | ~en;
  assign adv = en & ~chan_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= '0;
      frac_q <= '0;
    end else if (chan_wr) begin
      int_q  <= chan_int;
      frac_q <= chan_frac;
    end
  end

  fnmod_offset_sat #(.FRAC_W(FRAC_W), .MOD_W(MOD_W)) u_sat (
    .clk(clk), .rst(rst), .frac_i(frac_q), .mod_i(mod_off), .frac_o(frac_eff)
  );

  for (genvar k = 0; k < MASH_ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stage_in[k] = frac_eff;
    end else begin : g_next
      assign stage_in[k] = stage_sum[k-1];
    end
    fnmod_mash_stage #(.W(FRAC_W)) u_acc (
      .clk(clk), .rst(rst), .clr(clr), .adv(adv),
      .in_i(stage_in[k]), .sum_o(stage_sum[k]), .carry_o(carry[k])
    );
  end

  fnmod_noise_cancel u_nc (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv),
    .c1(carry[0]), .c2(carry[1]), .c3(carry[2]), .corr_o(corr)
  );

  assign div_next = $signed({1'b0, int_q}) + OUT_W'(corr);

  always_ff @(posedge clk) begin
    if (rst)
      div_out <= '0;
    else if (chan_wr)
      div_out <= {1'b0, chan_int};
    else if (!en)
      div_out <= {1'b0, int_q};
    else
      div_out <= $unsigned(div_next);
  end

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    chan_wr |=> div_out == {1'b0, $past(chan_int)});
  // R3
  idle_int_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !chan_wr) |=> div_out == {1'b0, $past(int_q)});
  // R6
  corr_window_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !chan_wr) |=> (int'(div_out) + 3 >= int'($past(int_q)) &&
                          int'(div_out) <= int'($past(int_q)) + 4));
endmodule

// File: tb/fracn_div_mod_bench.sv
module fracn_div_mod_bench;
  localparam int MASK = (1 << 23) - 1;

  logic        clk = 1'b0;
  logic        rst, en, chan_wr;
  logic [7:0]  chan_int;
  logic [22:0] chan_frac;
  logic [15:0] mod_off;
  logic [8:0]  div_out;

  int checks = 0, errors = 0;
  int m_int = 0, m_frac = 0, m_div = 0;
  int a1 = 0, a2 = 0, a3 = 0, c2d = 0, c3d = 0, c3dd = 0;
  int last_div = 0;

  always #5 clk = ~clk;

  fracn_div_mod u_fracn_div_mod (
    .clk(clk), .rst(rst), .en(en), .chan_wr(chan_wr), .chan_int(chan_int),
    .chan_frac(chan_frac), .mod_off(mod_off), .div_out(div_out)
  );

  function automatic int eff_frac(int f, int mo);
    int s;
    s = f + mo;
    if (s < 0) return 0;
    if (s > MASK) return MASK;
    return s;
  endfunction

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: div_out=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic model_clear();
    a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
  endtask

  task automatic step(bit e, bit w, int ci, int cf, int mo, string tag);
    int f, s, c1, c2, c3, y, mval;
    logic [15:0] mbits;
    en = e; chan_wr = w; chan_int = ci[7:0]; chan_frac = cf[22:0];
    mbits = mo[15:0]; mod_off = mbits;
    mval = int'($signed(mbits));
    if (w) begin
      m_int = ci; m_frac = cf; model_clear(); m_div = ci;
    end else if (!e) begin
      model_clear(); m_div = m_int;
    end else begin
      f = eff_frac(m_frac, mval);
      s = a1 + f; c1 = s >> 23; a1 = s & MASK;
      s = a2 + a1; c2 = s >> 23; a2 = s & MASK;
      s = a3 + a2; c3 = s >> 23; a3 = s & MASK;
      y = c1 + c2 - c2d + c3 - 2 * c3d + c3dd;
      c3dd = c3d; c3d = c3; c2d = c2;
      m_div = m_int + y;
    end
    @(posedge clk); #1;
    last_div = int'(div_out);
    check(last_div, m_div, tag);
  endtask

  task automatic mean_run(int ci, int cf, int n, string tag);
    longint total;
    real ideal, dev;
    step(1, 1, ci, cf, 0, tag);
    total = 0;
    for (int i = 0; i < n; i++) begin
      step(1, 0, ci, cf, 0, tag);
      total += last_div;
    end
    ideal = real'(n) * (real'(ci) + real'(cf) / 8388608.0);
    dev = real'(total) - ideal;
    if (dev < 0.0) dev = -dev;
    checks++;
    if (dev > 8.0) begin
      errors++;
      $display("FAIL %s: output sum=%0d expected %f", tag, total, ideal);
    end
  endtask

  initial begin
    #(10 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected end of stimulus");
    finish_run();
  end

  initial begin
    int r, ci, cf, mo;
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; en = 1'b0; chan_wr = 1'b0; chan_int = '0; chan_frac = '0; mod_off = '0;
    repeat (3) @(posedge clk);
    #1;
    check(int'(div_out), 0, "R1 reset value");
    rst = 1'b0;
    step(1, 0, 0, 0, 0, "R1 zero state after reset");

    // R2: load and sequence start
    step(1, 1, 100, 23'h123456, 0, "R2 write loads integer");
    for (int i = 0; i < 40; i++) step(1, 0, 100, 23'h123456, 0, "R5 R6 sequence");
    // R2: write while disabled still loads
    step(0, 1, 77, 23'h654321, 0, "R2 write priority over en");
    for (int i = 0; i < 10; i++) step(1, 0, 77, 23'h654321, 0, "R2 restart from clear");

    // R8: zero fraction is exact
    step(1, 1, 50, 0, 0, "R8 write");
    for (int i = 0; i < 20; i++) step(1, 0, 50, 0, 0, "R8 integer only");

    // R4: low clamp turns fraction to zero
    step(1, 1, 60, 10, 0, "R4 write");
    for (int i = 0; i < 20; i++) step(1, 0, 60, 10, -1000, "R4 clamp low");
    // R4: high clamp at full scale
    step(1, 1, 90, MASK - 5, 0, "R4 write");
    for (int i = 0; i < 30; i++) step(1, 0, 90, MASK - 5, 32767, "R4 clamp high");
    for (int i = 0; i < 30; i++) step(1, 0, 90, 23'h200000, -32768, "R4 negative full offset");

    // R3: disabled output ignores modulation, then resumes cleanly
    step(1, 1, 120, 23'h3FFFFF, 0, "R3 write");
    for (int i = 0; i < 7; i++) step(1, 0, 120, 23'h3FFFFF, 5000, "R3 run");
    for (int i = 0; i < 15; i++) step(0, 0, 120, 23'h3FFFFF, int'($urandom), "R3 disabled");
    for (int i = 0; i < 15; i++) step(1, 0, 120, 23'h3FFFFF, 0, "R3 resume");

    // R7: long-run mean
    mean_run(40, 23'h2AAAAA, 6000, "R7 mean third");
    mean_run(200, 23'h400000, 3000, "R7 mean half");
    mean_run(3, 23'h000011, 3000, "R7 mean tiny fraction");

    // R5 R6: random traffic
    ci = 100; cf = 23'h0F0F0F;
    step(1, 1, ci, cf, 0, "R2 random start");
    for (int i = 0; i < 3000; i++) begin
      r = int'($urandom % 100);
      mo = int'($signed(16'($urandom)));
      if (r < 3) begin
        ci = 3 + int'($urandom % 250);
        cf = int'($urandom) & MASK;
        step(r[0], 1, ci, cf, mo, "R2 random write");
      end else if (r < 10) begin
        step(0, 0, ci, cf, mo, "R3 random idle");
      end else begin
        step(1, 0, ci, cf, mo, "R5 R6 random run");
      end
    end

    finish_run();
  end
endmodule